// File: doc/BRIEF.md
# DMA Descriptor Link Coherency Guard

This block holds the control word of one transfer descriptor for each of sixteen DMA channels. Each word has four parts: a link enable, a scatter/gather enable, a four-bit link channel and a done flag. The CPU writes and reads the word of the channel it addresses. A DMA engine stub starts channels and retires them. When a channel starts, its done flag clears. When it retires, its done flag sets. On retirement the stored enables are sampled and, if set, turn into a link start request for the linked channel or a scatter/gather reload request for the retiring channel.

Software may set an enable while a channel is still running. The engine may retire that channel at the same moment. The guard settles this race. A write to a channel whose done flag is set, or which retires in the same cycle, has both enables stored as zero. Software writes 1 to an enable and reads the word back: a 1 means the request will be honoured at retirement, and a 0 means the channel had already finished.

Top module: `dmaLinkGuard`

## Requirements
- R1: After reset every channel's control word reads zero, and neither request output is asserted.
- R2: The control word layout is bit 0 link enable, bit 1 scatter/gather enable, bits 5:2 link channel and bit 6 done. A write to a channel whose done flag is clear stores bits 5:0 as written, and the read port returns the addressed channel's word in the same cycle.
- R3: A write to a channel whose done flag is set stores both enables as 0 and still stores the written link channel field.
- R4: Writing 0 to bit 6 clears the done flag, effective after the write. Writing 1 to bit 6 never sets it. The force in R3 uses the done flag held before that write.
- R5: A start on a channel clears its done flag in the next cycle.
- R6: A retirement sets the channel's done flag in the next cycle. A retirement wins over a start on the same channel in the same cycle.
- R7: In the cycle after a retirement whose stored link enable is 1, linkReq is high for one cycle and linkReqCh carries the stored link channel. A link enable of 0 gives no link request.
- R8: In the cycle after a retirement whose stored scatter/gather enable is 1, sgReq is high for one cycle and sgReqCh carries the retiring channel.
- R9: The enables are sampled at retirement, not at start. A change written between start and retirement decides the requests.
- R10: If a CPU write and a retirement hit the same channel in one cycle, retirement is applied first. The written enables are stored as 0, the requests use the enables held before that cycle, and the done flag ends set.
- R11: With the link enable at 0, the link channel field is kept exactly as written across retirement and acts as a software tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 4 | Channel addressed by the CPU for reads and writes |
| cpuWrEn | input | 1 | CPU write strobe |
| cpuWrData | input | 7 | Control word written by the CPU |
| cpuRdData | output | 7 | Control word of the addressed channel |
| engStart | input | 1 | Engine starts a channel |
| engStartCh | input | 4 | Channel being started |
| engRetire | input | 1 | Engine retires a channel |
| engRetireCh | input | 4 | Channel being retired |
| linkReq | output | 1 | Link start request pulse |
| linkReqCh | output | 4 | Channel to start for the link |
| sgReq | output | 1 | Scatter/gather reload request pulse |
| sgReqCh | output | 4 | Channel to reload |

## Verification
The main path is driven from a table of channel and control word pairs. Each pair is written with done clear, read back, started and retired. The pairs cover no enable, link only, scatter/gather only, both enables, and a tag written with the link enable off. Together they show whether each enable maps to its own request, whether the request channel comes from the right source, and whether the fields survive retirement unchanged. Directed cases then try four things: a write to an already-done channel, the clear-then-set sequence on the done flag, an enable changed between start and retirement, and a write that lands on the retirement cycle. These separate the force rule, the timing of the done flag and the order in which retirement and write are applied.

// File: rtl/dlg_pkg.sv
package dlg_pkg;
  localparam int NUM_CH = 16;
  localparam int CH_W = $clog2(NUM_CH);
  localparam int WORD_W = CH_W + 3;

  // Control word: done at the top, then link channel, then the two enables.
  typedef struct packed {
    logic            done;
    logic [CH_W-1:0] linkCh;
    logic            sgEn;
    logic            linkEn;
  } ctrl_word_t;

  // Strobes from control to the datapath.
  typedef struct packed {
    logic            wr;
    logic            wrForce;
    logic [CH_W-1:0] wrCh;
    logic            ret;
    logic [CH_W-1:0] retCh;
    logic            start;
    logic [CH_W-1:0] startCh;
  } strobe_t;
endpackage

// File: rtl/dlg_ctrl.sv
module dlg_ctrl
  import dlg_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [CH_W-1:0] cpuAddr,
  input  logic            cpuWrEn,
  input  logic            engStart,
  input  logic [CH_W-1:0] engStartCh,
  input  logic            engRetire,
  input  logic [CH_W-1:0] engRetireCh,
  input  logic [NUM_CH-1:0] doneVec,
  input  ctrl_word_t      retWord,
  output strobe_t         stb,
  output logic            linkReq,
  output logic [CH_W-1:0] linkReqCh,
  output logic            sgReq,
  output logic [CH_W-1:0] sgReqCh
);
  logic retHitsWrite;

  // Retirement is applied before a write on the same channel.
  assign retHitsWrite = engRetire && (engRetireCh == cpuAddr);

  always_comb begin
    stb.wr      = cpuWrEn;
    stb.wrCh    = cpuAddr;
    stb.wrForce = doneVec[cpuAddr] || retHitsWrite;
    stb.ret     = engRetire;
    stb.retCh   = engRetireCh;
    stb.start   = engStart;
    stb.startCh = engStartCh;
  end

  // The enables held before the retirement edge decide the requests.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkReq   <= 1'b0;
      linkReqCh <= '0;
      sgReq     <= 1'b0;
      sgReqCh   <= '0;
    end else begin
      linkReq   <= engRetire && retWord.linkEn;
      linkReqCh <= retWord.linkCh;
      sgReq     <= engRetire && retWord.sgEn;
      sgReqCh   <= engRetireCh;
    end
  end

  AST_LINK_FROM_RETIRE: assert property (@(posedge clk) disable iff (!rstN)
    linkReq |-> ($past(engRetire) && linkReqCh == $past(retWord.linkCh))); // R7
  AST_SG_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    sgReq |-> ($past(engRetire) && sgReqCh == $past(engRetireCh))); // R8
  AST_LINK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (linkReq && !$past(engRetire)) |-> 1'b0); // R7
endmodule

// File: rtl/dlg_store.sv
module dlg_store
  import dlg_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  ctrl_word_t      wrData,
  input  logic [CH_W-1:0] rdAddr,
  output ctrl_word_t      rdData,
  output ctrl_word_t      retWord,
  output logic [NUM_CH-1:0] doneVec
);
  ctrl_word_t wordQ [NUM_CH];
  ctrl_word_t wordD [NUM_CH];

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      wordD[i] = wordQ[i];
      if (stb.wr && stb.wrCh == CH_W'(i)) begin
        wordD[i].linkCh = wrData.linkCh;
        wordD[i].linkEn = wrData.linkEn && !stb.wrForce;
        wordD[i].sgEn   = wrData.sgEn && !stb.wrForce;
        wordD[i].done   = wordQ[i].done && wrData.done;
      end
      if (stb.start && stb.startCh == CH_W'(i)) wordD[i].done = 1'b0;
      if (stb.ret && stb.retCh == CH_W'(i)) wordD[i].done = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_CH; i++) begin
      if (!rstN) wordQ[i] <= '0;
      else       wordQ[i] <= wordD[i];
    end
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : gDone
      assign doneVec[g] = wordQ[g].done;
    end
  endgenerate

  assign rdData  = wordQ[rdAddr];
  assign retWord = wordQ[stb.retCh];

  AST_DONE_FORCES: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wr && wordQ[stb.wrCh].done) |=>
      (!wordQ[$past(stb.wrCh)].linkEn && !wordQ[$past(stb.wrCh)].sgEn)); // R3
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.start && !(stb.ret && stb.retCh == stb.startCh)) |=>
      !wordQ[$past(stb.startCh)].done); // R5
  AST_RETIRE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    stb.ret |=> wordQ[$past(stb.retCh)].done); // R6
  AST_COLLIDE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wr && stb.ret && stb.wrCh == stb.retCh) |=>
      (!wordQ[$past(stb.wrCh)].linkEn && !wordQ[$past(stb.wrCh)].sgEn)); // R10
  AST_TAG_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    stb.wr |=> wordQ[$past(stb.wrCh)].linkCh == $past(wrData.linkCh)); // R11
endmodule

// File: rtl/dmaLinkGuard.sv
module dmaLinkGuard
  import dlg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CH_W-1:0]   cpuAddr,
  input  logic              cpuWrEn,
  input  logic [WORD_W-1:0] cpuWrData,
  output logic [WORD_W-1:0] cpuRdData,
  input  logic              engStart,
  input  logic [CH_W-1:0]   engStartCh,
  input  logic              engRetire,
  input  logic [CH_W-1:0]   engRetireCh,
  output logic              linkReq,
  output logic [CH_W-1:0]   linkReqCh,
  output logic              sgReq,
  output logic [CH_W-1:0]   sgReqCh
);
  strobe_t     stb;
  ctrl_word_t  rdWord;
  ctrl_word_t  retWord;
  logic [NUM_CH-1:0] doneVec;

  dlg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrEn(cpuWrEn),
    .engStart(engStart), .engStartCh(engStartCh),
    .engRetire(engRetire), .engRetireCh(engRetireCh),
    .doneVec(doneVec), .retWord(retWord), .stb(stb),
    .linkReq(linkReq), .linkReqCh(linkReqCh),
    .sgReq(sgReq), .sgReqCh(sgReqCh)
  );

  dlg_store store_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(ctrl_word_t'(cpuWrData)),
    .rdAddr(cpuAddr), .rdData(rdWord), .retWord(retWord), .doneVec(doneVec)
  );

  assign cpuRdData = rdWord;
endmodule

// File: tb/dmaLinkGuard_tb.sv
module dmaLinkGuard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {channel[3:0], linkCh[3:0], sgEn, linkEn}
  localparam logic [9:0] VEC [NVEC] = '{
    {4'd0,  4'd0,  1'b0, 1'b0},
    {4'd3,  4'd9,  1'b0, 1'b1},
    {4'd7,  4'd2,  1'b1, 1'b0},
    {4'd15, 4'd0,  1'b1, 1'b1},
    {4'd9,  4'd12, 1'b0, 1'b0},
    {4'd12, 4'd15, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] cpuAddr = '0;
  logic cpuWrEn = 1'b0;
  logic [6:0] cpuWrData = '0;
  logic [6:0] cpuRdData;
  logic engStart = 1'b0;
  logic [3:0] engStartCh = '0;
  logic engRetire = 1'b0;
  logic [3:0] engRetireCh = '0;
  logic linkReq, sgReq;
  logic [3:0] linkReqCh, sgReqCh;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmaLinkGuard dut_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrEn(cpuWrEn),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData),
    .engStart(engStart), .engStartCh(engStartCh),
    .engRetire(engRetire), .engRetireCh(engRetireCh),
    .linkReq(linkReq), .linkReqCh(linkReqCh),
    .sgReq(sgReq), .sgReqCh(sgReqCh)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog expired: actual %0d cycles expected below 5000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(string req, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic readWord(input logic [3:0] ch, output logic [6:0] w);
    cpuAddr = ch;
    #1;
    w = cpuRdData;
  endtask

  task automatic writeWord(input logic [3:0] ch, input logic [6:0] d);
    cpuAddr = ch; cpuWrData = d; cpuWrEn = 1'b1;
    @(negedge clk);
    cpuWrEn = 1'b0;
  endtask

  task automatic startCh(input logic [3:0] ch);
    engStartCh = ch; engStart = 1'b1;
    @(negedge clk);
    engStart = 1'b0;
  endtask

  task automatic retireCh(input logic [3:0] ch);
    engRetireCh = ch; engRetire = 1'b1;
    @(negedge clk);
    engRetire = 1'b0;
  endtask

  initial begin
    logic [6:0] w;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int c = 0; c < 16; c++) begin
      readWord(4'(c), w);
      check("R1 word", w, 0);
    end
    check("R1 linkReq", linkReq, 0);
    check("R1 sgReq", sgReq, 0);

    // Table walk: write, read back, start, retire, check requests
    for (int v = 0; v < NVEC; v++) begin
      logic [3:0] ch;
      logic [5:0] d;
      ch = VEC[v][9:6];
      d  = VEC[v][5:0];
      writeWord(ch, {1'b0, d});
      readWord(ch, w);
      check("R2 readback", w, {1'b0, d});
      startCh(ch);
      retireCh(ch);
      check("R7 linkReq", linkReq, d[0]);
      if (d[0]) check("R7 linkReqCh", linkReqCh, d[5:2]);
      check("R8 sgReq", sgReq, d[1]);
      if (d[1]) check("R8 sgReqCh", sgReqCh, ch);
      @(negedge clk);
      check("R7 link pulse ends", linkReq, 0);
      check("R8 sg pulse ends", sgReq, 0);
      readWord(ch, w);
      check("R6 done after retire / R11 fields kept", w, {1'b1, d});
    end

    // R3: write to a done channel forces enables off, keeps link channel
    writeWord(4'd3, {1'b1, 4'd5, 1'b1, 1'b1});
    readWord(4'd3, w);
    check("R3 forced", w, {1'b1, 4'd5, 1'b0, 1'b0});

    // R4: clearing done in the same write still forced (old done used)
    writeWord(4'd3, {1'b0, 4'd5, 1'b0, 1'b1});
    readWord(4'd3, w);
    check("R4 clear done forced", w, {1'b0, 4'd5, 1'b0, 1'b0});
    // R4: writing 1 to done does not set it; enables now accepted
    writeWord(4'd3, {1'b1, 4'd5, 1'b0, 1'b1});
    readWord(4'd3, w);
    check("R4 done not set", w, {1'b0, 4'd5, 1'b0, 1'b1});

    // R9: change enables between start and retire
    startCh(4'd3);
    writeWord(4'd3, {1'b0, 4'd6, 1'b1, 1'b0});
    retireCh(4'd3);
    check("R9 linkReq", linkReq, 0);
    check("R9 sgReq", sgReq, 1);
    check("R9 sgReqCh", sgReqCh, 3);

    // R10: write and retire on the same channel in one cycle
    writeWord(4'd4, {1'b0, 4'd8, 1'b0, 1'b1});
    startCh(4'd4);
    cpuAddr = 4'd4; cpuWrData = {1'b0, 4'd10, 1'b1, 1'b1}; cpuWrEn = 1'b1;
    engRetireCh = 4'd4; engRetire = 1'b1;
    @(negedge clk);
    cpuWrEn = 1'b0; engRetire = 1'b0;
    check("R10 linkReq", linkReq, 1);
    check("R10 linkReqCh", linkReqCh, 8);
    check("R10 sgReq", sgReq, 0);
    readWord(4'd4, w);
    check("R10 word", w, {1'b1, 4'd10, 1'b0, 1'b0});

    // R6: start and retire together on one channel leave done set
    engStartCh = 4'd5; engStart = 1'b1;
    engRetireCh = 4'd5; engRetire = 1'b1;
    @(negedge clk);
    engStart = 1'b0; engRetire = 1'b0;
    readWord(4'd5, w);
    check("R6 retire beats start", w[6], 1);
    // R5: start alone clears done
    startCh(4'd5);
    readWord(4'd5, w);
    check("R5 start clears", w[6], 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule